// File: doc/BRIEF.md
# Configurable Synchronous Burst Read Sequencer

This block is the read-timing engine of a memory that can serve either single asynchronous reads or synchronous bursts. A host loads a 16-bit configuration word. That word sets the read mode, the initial access latency in clock cycles, the burst length and the timing of an active-low wait indicator. When a read request arrives in synchronous mode, the block counts out the latency. It then streams consecutive 32-bit words, one per rising clock edge. The words come in linear order and wrap inside the naturally aligned block of the burst size.

The memory array is modelled as a combinational word lookup. In asynchronous mode, or when the burst-length field holds a code that does not enable bursts, a request returns a single word on the next edge. While a burst is in flight the block reports itself busy. It then rejects both new read requests and configuration writes.

Top module: `burst_read_seq`

## Requirements
- R1: After a synchronous active-high reset, `cfg_rdata` reads 16'h9CC3, `wait_n` is high, `dout_valid` is low and `busy` is low.
- R2: A configuration write stores `cfg_wdata` with bits 14, 5, 4 and 3 forced to 0, so they always read back 0. The other bits read back as written. The write takes effect on the edge where `cfg_we` is sampled high.
- R3: A configuration write is ignored while `busy` is high, and also on the edge where `rd_start` is accepted.
- R4: A synchronous burst runs only when bit 15 is 0 and bits 2:0 are 001, 010 or 011. Every other setting gives asynchronous reads. In that case an accepted `rd_start` presents the addressed word with `dout_valid` high for one cycle after that edge, while `wait_n` stays high and `busy` stays low.
- R5: Bits 13:10 hold a latency code c, giving D = c+2 for c from 0 to 7 and D = 9 for c from 8 to 15. Counting the edge that accepts `rd_start` as edge 0, the first burst word is valid after edge D.
- R6: Bits 2:0 codes 001, 010 and 011 give bursts of 2, 4 and 8 words. The words come on consecutive edges, each held exactly one cycle, and `dout_valid` is low after the last one.
- R7: Burst word i comes from address (A with its low log2(N) bits replaced by (A+i) mod N). For example, 4 words from offset 2 read offsets 2, 3, 0, 1.
- R8: With bit 8 at 0, `wait_n` is low after edges 0 to D-1 of a burst and high from edge D. With bit 8 at 1 it is low after edges 0 to D-2 and high from edge D-1. It is high at all other times.
- R9: `busy` is high after edges 0 to D+N-1 of a burst. An `rd_start` that arrives while `busy` is high is ignored.
- R10: The word at address a is (a zero-extended to 32 bits) multiplied by 32'h9E3779B1, modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word to store |
| cfg_rdata | output | 16 | Current configuration word |
| rd_start | input | 1 | Read request, sampled when idle |
| rd_addr | input | AW (10) | Word address of the read |
| dout | output | DW (32) | Read data word |
| dout_valid | output | 1 | High for each cycle that `dout` carries a word |
| wait_n | output | 1 | Active-low wait indicator during the initial latency |
| busy | output | 1 | High while a synchronous burst is in flight |

## Verification
The hardest situation to reach is a configuration write or a second read request that lands inside a burst, at a specific cycle. This includes the edge that starts the burst and the final edge, where the sequencer is about to return to idle. The stimulus injects such a collision at a randomly chosen cycle within the burst window, as well as on the start edge itself. The bench then checks that the data stream, the wait timing and the stored word are all undisturbed. Random configurations also cover the extreme latencies, the clamped latency codes and the early-wait setting at the minimum latency of 2, where the wait pulse shrinks to a single cycle.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  localparam int CFG_W     = 16;
  localparam int MODE_BIT  = 15;
  localparam int LAT_LSB   = 10;
  localparam int LAT_W     = 4;
  localparam int EARLY_BIT = 8;
  localparam int LEN_LSB   = 0;
  localparam int LEN_W     = 3;
  localparam int CNT_W     = 4;
  localparam int LAT_BASE  = 2;
  localparam int LAT_TOP   = 9;

  localparam logic [CFG_W-1:0] CFG_KEEP  = 16'hBFC7;
  localparam logic [CFG_W-1:0] CFG_RESET = 16'h9CC3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_DATA  = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic             sync_en;
    logic [CNT_W-1:0] lat;
    logic             wait_early;
    logic [CNT_W-1:0] beats;
  } cfg_dec_t;

  function automatic cfg_dec_t decode_cfg(input logic [CFG_W-1:0] c);
    cfg_dec_t         d;
    logic [LAT_W-1:0] code;
    logic [LEN_W-1:0] len;
    code = c[LAT_LSB +: LAT_W];
    len  = c[LEN_LSB +: LEN_W];
    d.sync_en    = !c[MODE_BIT] && (len == 3'd1 || len == 3'd2 || len == 3'd3);
    d.lat        = (code > CNT_W'(LAT_TOP - LAT_BASE)) ? CNT_W'(LAT_TOP)
                                                        : code + CNT_W'(LAT_BASE);
    d.wait_early = c[EARLY_BIT];
    d.beats      = d.sync_en ? (CNT_W'(1) << len) : CNT_W'(1);
    return d;
  endfunction

endpackage

// File: rtl/cfg_store.sv
module cfg_store #(
  parameter int W = 16,
  parameter logic [W-1:0] RST_VAL = '0,
  parameter logic [W-1:0] KEEP    = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] value
);

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= RST_VAL;
    end else if (wr_en) begin
      value <= wr_data & KEEP;
    end
  end

endmodule

// File: rtl/wrap_addr.sv
module wrap_addr #(
  parameter int AW    = 10,
  parameter int IDX_W = 4
) (
  input  logic [AW-1:0]    base,
  input  logic [IDX_W-1:0] idx,
  input  logic [IDX_W-1:0] span,
  output logic [AW-1:0]    addr
);

  logic [AW-1:0] low_mask;
  logic [AW-1:0] stepped;

  assign low_mask = AW'(span) - AW'(1);
  assign stepped  = base + AW'(idx);

  for (genvar i = 0; i < AW; i++) begin : g_bit
    assign addr[i] = low_mask[i] ? stepped[i] : base[i];
  end

endmodule

// File: rtl/word_rom.sv
module word_rom #(
  parameter int AW = 10,
  parameter int DW = 32,
  parameter logic [DW-1:0] MULT = 32'h9E3779B1
) (
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] data
);

  logic [DW-1:0] wide_addr;

  assign wide_addr = DW'(addr);
  assign data      = wide_addr * MULT;

endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_seq_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [AW-1:0]    start_addr,
  input  cfg_dec_t         dec,
  input  logic [DW-1:0]    mem_data,
  output logic [AW-1:0]    sel_base,
  output logic [CNT_W-1:0] sel_idx,
  output logic [CNT_W-1:0] sel_span,
  output logic [DW-1:0]    dout,
  output logic             dout_valid,
  output logic             wait_n,
  output logic             busy
);

  seq_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] beat_q;
  logic [CNT_W-1:0] lat_q;
  logic [CNT_W-1:0] beats_q;
  logic             early_q;
  logic [AW-1:0]    base_q;

  always_comb begin
    sel_base = (state_q == ST_IDLE) ? start_addr : base_q;
    sel_idx  = (state_q == ST_DATA) ? beat_q : '0;
    sel_span = (state_q == ST_IDLE) ? CNT_W'(1) : beats_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      beat_q     <= '0;
      lat_q      <= CNT_W'(LAT_TOP);
      beats_q    <= CNT_W'(1);
      early_q    <= 1'b0;
      base_q     <= '0;
      dout       <= '0;
      dout_valid <= 1'b0;
      wait_n     <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          wait_n     <= 1'b1;
          dout_valid <= 1'b0;
          if (start) begin
            if (dec.sync_en) begin
              state_q <= ST_DELAY;
              cnt_q   <= CNT_W'(1);
              base_q  <= start_addr;
              lat_q   <= dec.lat;
              early_q <= dec.wait_early;
              beats_q <= dec.beats;
              wait_n  <= 1'b0;
            end else begin
              dout       <= mem_data;
              dout_valid <= 1'b1;
            end
          end
        end
        ST_DELAY: begin
          if (cnt_q == lat_q) begin
            dout       <= mem_data;
            dout_valid <= 1'b1;
            beat_q     <= CNT_W'(1);
            wait_n     <= 1'b1;
            state_q    <= ST_DATA;
          end else begin
            cnt_q  <= cnt_q + CNT_W'(1);
            wait_n <= early_q && (cnt_q + CNT_W'(1) == lat_q);
          end
        end
        ST_DATA: begin
          wait_n <= 1'b1;
          if (beat_q < beats_q) begin
            dout       <= mem_data;
            dout_valid <= 1'b1;
            beat_q     <= beat_q + CNT_W'(1);
          end else begin
            dout_valid <= 1'b0;
            state_q    <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
  import burst_seq_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 32,
  parameter logic [DW-1:0] MEM_MULT = 32'h9E3779B1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             rd_start,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    dout,
  output logic             dout_valid,
  output logic             wait_n,
  output logic             busy
);

  cfg_dec_t         dec;
  logic             cfg_take;
  logic [AW-1:0]    sel_base;
  logic [CNT_W-1:0] sel_idx;
  logic [CNT_W-1:0] sel_span;
  logic [AW-1:0]    mem_addr;
  logic [DW-1:0]    mem_data;

  assign cfg_take = cfg_we && !busy && !rd_start;
  assign dec      = decode_cfg(cfg_rdata);

  cfg_store #(
    .W      (CFG_W),
    .RST_VAL(CFG_RESET),
    .KEEP   (CFG_KEEP)
  ) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (cfg_take),
    .wr_data(cfg_wdata),
    .value  (cfg_rdata)
  );

  burst_ctrl #(
    .AW(AW),
    .DW(DW)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (rd_start),
    .start_addr(rd_addr),
    .dec       (dec),
    .mem_data  (mem_data),
    .sel_base  (sel_base),
    .sel_idx   (sel_idx),
    .sel_span  (sel_span),
    .dout      (dout),
    .dout_valid(dout_valid),
    .wait_n    (wait_n),
    .busy      (busy)
  );

  wrap_addr #(
    .AW   (AW),
    .IDX_W(CNT_W)
  ) u_wrap (
    .base(sel_base),
    .idx (sel_idx),
    .span(sel_span),
    .addr(mem_addr)
  );

  word_rom #(
    .AW  (AW),
    .DW  (DW),
    .MULT(MEM_MULT)
  ) u_rom (
    .addr(mem_addr),
    .data(mem_data)
  );

endmodule

// File: rtl/burst_read_seq_chk.sv
module burst_read_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        cfg_we,
  input logic [15:0] cfg_rdata,
  input logic        rd_start,
  input logic        dout_valid,
  input logic        wait_n,
  input logic        busy
);

  logic       sync_cfg;
  logic       take;
  logic [7:0] vcnt;
  logic [7:0] exp_beats;

  assign sync_cfg = !cfg_rdata[15] &&
                    (cfg_rdata[2:0] == 3'd1 || cfg_rdata[2:0] == 3'd2 || cfg_rdata[2:0] == 3'd3);
  assign take = rd_start && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      vcnt      <= '0;
      exp_beats <= '0;
    end else if (take) begin
      vcnt      <= '0;
      exp_beats <= sync_cfg ? (8'd1 << cfg_rdata[2:0]) : 8'd0;
    end else if (dout_valid) begin
      vcnt <= vcnt + 8'd1;
    end
  end

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata[14] == 1'b0) && (cfg_rdata[5:3] == 3'b000));

  p_cfg_frozen_busy_r3: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(cfg_rdata));

  p_cfg_start_edge_r3: assert property (@(posedge clk) disable iff (rst)
    (take && cfg_we) |=> $stable(cfg_rdata));

  p_async_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    (take && !sync_cfg) |=> (dout_valid && wait_n && !busy));

  p_sync_enter_r9: assert property (@(posedge clk) disable iff (rst)
    (take && sync_cfg) |=> (busy && !wait_n && !dout_valid));

  p_idle_wait_high_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> wait_n);

  p_data_wait_high_r8: assert property (@(posedge clk) disable iff (rst)
    dout_valid |-> wait_n);

  p_beat_count_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (vcnt == exp_beats));

endmodule

bind burst_read_seq burst_read_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_we    (cfg_we),
  .cfg_rdata (cfg_rdata),
  .rd_start  (rd_start),
  .dout_valid(dout_valid),
  .wait_n    (wait_n),
  .busy      (busy)
);

// File: tb/tb_burst_read_seq.sv
module tb_burst_read_seq;

  localparam int AW = 10;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [15:0]   cfg_wdata = '0;
  logic [15:0]   cfg_rdata;
  logic          rd_start = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] dout;
  logic          dout_valid;
  logic          wait_n;
  logic          busy;

  int          n_chk = 0;
  int          n_fail = 0;
  logic [15:0] cur_cfg = 16'h9CC3;

  always #2 clk = ~clk;

  burst_read_seq #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .rd_start(rd_start), .rd_addr(rd_addr),
    .dout(dout), .dout_valid(dout_valid), .wait_n(wait_n), .busy(busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of(input int a);
    logic [31:0] x;
    x = 32'(a & ((1 << AW) - 1));
    return x * 32'h9E3779B1;
  endfunction

  function automatic int wrap_of(input int a, input int i, input int n);
    return ((a & ~(n - 1)) | ((a + i) & (n - 1))) & ((1 << AW) - 1);
  endfunction

  function automatic logic [15:0] mk(input bit rm, input int code, input bit early, input int bl);
    return (16'(rm) << 15) | (16'(code & 15) << 10) | (16'(early) << 8) | 16'h00C0 | 16'(bl & 7);
  endfunction

  task automatic write_cfg(input logic [15:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    cur_cfg = v & 16'hBFC7;
    chk("R2 cfg readback", 32'(cfg_rdata), 32'(cur_cfg));
  endtask

  task automatic do_read(input int a, input int poke_t, input bit poke_we,
                         input logic [15:0] poke_val, input bit poke_start);
    bit sync;
    int bl, code, d, n, last;
    bit early;
    bl    = int'(cur_cfg[2:0]);
    code  = int'(cur_cfg[13:10]);
    early = cur_cfg[8];
    sync  = !cur_cfg[15] && (bl >= 1 && bl <= 3);
    d     = (code > 7) ? 9 : code + 2;
    n     = sync ? (1 << bl) : 1;
    last  = sync ? d + n : 1;
    @(negedge clk);
    rd_start = 1'b1;
    rd_addr  = AW'(a);
    if (poke_t == 0 && poke_we) begin
      cfg_we = 1'b1;
      cfg_wdata = poke_val;
    end
    for (int t = 0; t <= last; t++) begin
      @(negedge clk);
      rd_start = 1'b0;
      cfg_we = 1'b0;
      if (sync) begin
        bit ev, ew;
        ev = (t >= d) && (t <= d + n - 1);
        ew = early ? (t >= d - 1) : (t >= d);
        chk("R5 R6 dout_valid", 32'(dout_valid), 32'(ev));
        if (ev) chk("R7 R10 burst word", dout, word_of(wrap_of(a, t - d, n)));
        chk("R8 wait_n", 32'(wait_n), 32'(ew));
        chk("R9 busy", 32'(busy), 32'(t <= d + n - 1));
      end else begin
        chk("R4 async dout_valid", 32'(dout_valid), 32'(t == 0));
        if (t == 0) chk("R4 R10 async word", dout, word_of(a));
        chk("R4 async wait_n", 32'(wait_n), 32'd1);
        chk("R4 async busy", 32'(busy), 32'd0);
      end
      if (t + 1 == poke_t) begin
        if (poke_we) begin
          cfg_we = 1'b1;
          cfg_wdata = poke_val;
        end
        if (poke_start) begin
          rd_start = 1'b1;
          rd_addr  = AW'(~a);
        end
      end
    end
    chk("R3 cfg unchanged by read", 32'(cfg_rdata), 32'(cur_cfg));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset cfg", 32'(cfg_rdata), 32'h9CC3);
    chk("R1 reset wait_n", 32'(wait_n), 32'd1);
    chk("R1 reset dout_valid", 32'(dout_valid), 32'd0);
    chk("R1 reset busy", 32'(busy), 32'd0);

    do_read(37, -1, 0, 16'h0, 0);
    write_cfg(16'hFFFF);
    do_read(100, -1, 0, 16'h0, 0);

    write_cfg(mk(0, 0, 0, 1));
    do_read(5, -1, 0, 16'h0, 0);
    write_cfg(mk(0, 0, 1, 1));
    do_read(6, -1, 0, 16'h0, 0);
    write_cfg(mk(0, 15, 0, 2));
    do_read(9, -1, 0, 16'h0, 0);
    write_cfg(mk(0, 2, 0, 2));
    do_read(2, -1, 0, 16'h0, 0);
    write_cfg(mk(0, 7, 1, 3));
    do_read(13, -1, 0, 16'h0, 0);
    write_cfg(mk(0, 9, 1, 3));
    do_read(1023, -1, 0, 16'h0, 0);

    for (int bl = 0; bl < 8; bl++) begin
      if (bl >= 1 && bl <= 3) continue;
      write_cfg(mk(0, 3, 0, bl));
      do_read(200 + bl, -1, 0, 16'h0, 0);
    end
    write_cfg(mk(1, 0, 0, 3));
    do_read(77, -1, 0, 16'h0, 0);

    write_cfg(mk(0, 1, 0, 2));
    do_read(10, 3, 1, 16'h5555, 1);
    do_read(11, 0, 1, 16'h1234, 0);
    do_read(12, 7, 1, 16'h0000, 1);

    for (int it = 0; it < 60; it++) begin
      logic [15:0] c;
      int a, dd, nn, bl, pt;
      c  = mk(($urandom % 5) == 0, int'($urandom % 16), 1'($urandom % 2), int'($urandom % 8));
      write_cfg(c);
      a  = int'($urandom % 1024);
      bl = int'(cur_cfg[2:0]);
      dd = (int'(cur_cfg[13:10]) > 7) ? 9 : int'(cur_cfg[13:10]) + 2;
      nn = (!cur_cfg[15] && bl >= 1 && bl <= 3) ? (1 << bl) : 0;
      if (nn != 0 && ($urandom % 2) == 1) begin
        pt = 1 + int'($urandom % 32'(dd + nn));
        do_read(a, pt, 1'b1, 16'($urandom), 1'($urandom % 2));
      end else if (($urandom % 4) == 0) begin
        do_read(a, 0, 1'b1, 16'($urandom), 1'b0);
      end else begin
        do_read(a, -1, 1'b0, 16'h0, 1'b0);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule